// File: doc/BRIEF.md
# Flow-Through Synchronous Burst RAM

This block is a synthesizable model of a synchronous burst RAM with 32-bit words split into four byte lanes. The address, the chip selects, both address strobes, the advance input and every write control are sampled on the rising clock edge. Read data is not registered on its way out. It flows from the array to `dout` as soon as the edge has loaded the read address, so a read is visible in the same cycle that follows the edge.

An access can be started by either of two strobes. The processor strobe always opens with a read cycle, and any write it carries takes place on a later edge. The controller strobe decides between read and write from the write controls sampled at its own edge. Once an access is open, the next beats take their addresses from a two-bit wraparound counter. The counter steps in linear or interleaved order and moves only on edges where advance is low. The output drive flag `dout_en` goes low while a write is in progress. Output enable gates it without waiting for a clock edge.

The controller has three states. `ST_IDLE` means deselected, with no drive. `ST_READ` means the current beat is a read and output drive is allowed. `ST_WRITE` means the current beat wrote the array and drive is off. The transitions are:
- **start-read**: a selected access opened by the processor strobe, or by the controller strobe with no write request, goes to `ST_READ`.
- **start-write**: the controller strobe with a write request goes to `ST_WRITE`.
- **deselect**: a strobe taken while the device is not selected goes to `ST_IDLE`.
- **beat-read** and **beat-write**: with no strobe taken and the state not `ST_IDLE`, the next state is chosen by the write request.
- **hold-idle**: in `ST_IDLE` with no selected strobe, the block stays idle.

Top module: `fts_burst_sram`

## Requirements
- R1: After reset `dout_en` is 0 and the block is in `ST_IDLE` until a selected access starts.
- R2: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe taken at an edge without that combination closes the access. `dout_en` is then 0 from that edge, and write controls at the following edges write nothing until a selected access starts.
- R3: The processor strobe `adsp_n` is not taken while `ce1_n` is 1. At such an edge, if `adsc_n` is also high, the open access simply continues with its next beat.
- R4: At the edge where the processor strobe is taken, all write controls are ignored. That beat is a read of the new address.
- R5: At an edge that continues an open access, the write controls sampled at that edge decide the beat. If they ask for a write, `din` is written to the beat address. Otherwise the beat is a read.
- R6: The controller strobe `adsc_n`, when taken, loads the address and uses the write controls of the same edge. A write request stores `din` at that address, and no write request gives a read.
- R7: When both strobes are low and `ce1_n` is 0, the processor strobe wins and the controller strobe is ignored.
- R8: `gw_n`=0 writes all four bytes, whatever `bwe_n` and `bw_n` are.
- R9: With `gw_n`=1 and `bwe_n`=0, byte select `bw_n[i]`=0 writes bits 8i+7:8i only. With `gw_n`=1 and `bwe_n`=1 there is no write.
- R10: After an edge that writes any byte, `dout_en` is 0 even while `oe_n` is 0.
- R11: `oe_n`=1 forces `dout_en` to 0 at once, with no clock edge needed. Returning `oe_n` to 0 in a read beat restores the drive at once.
- R12: In a read beat, `dout` shows the array word at the beat address from the edge that set that address until the next edge.
- R13: With `mode`=0, captured at the start edge, the beat addresses step the two low address bits linearly with wraparound: start, +1, +2, +3, then back to start.
- R14: With `mode`=1, beat k uses the start low bits XOR k. An edge with `adv_n`=1 keeps the current beat address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Byte selects, active low, bit i for byte lane i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, flow-through from the array |
| dout_en | output | 1 | High when `dout` should be driven onto the shared bus |

## Verification
All results are due one edge after the stimulus that causes them, with no extra latency. The edge that samples a strobe, a beat or a write sets `dout_en` and `dout` at once, because the array read path is combinational from the registered address. Output enable has no edge in its path. The bench therefore drives inputs at the falling edge and lets the rising edge capture them. It compares `dout_en` and `dout` with its reference model at the next falling edge. The asynchronous output-enable checks are taken a few nanoseconds after `oe_n` moves, inside the same cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } fts_state_e;

    localparam int FTS_LANES  = 4;
    localparam int FTS_LANE_W = 8;
    localparam int FTS_CNT_W  = 2;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_lsb,
    input  logic          load_ilv,
    input  logic          step,
    output logic [CW-1:0] cur_lsb,
    output logic [CW-1:0] nxt_lsb
);
    logic [CW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic          ilv_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else if (load) begin
            base_q <= load_lsb;
            cnt_q  <= '0;
            ilv_q  <= load_ilv;
        end else if (step) begin
            cnt_q  <= cnt_inc;
        end
    end

    always_comb begin
        if (ilv_q) begin
            cur_lsb = base_q ^ cnt_q;
            nxt_lsb = base_q ^ cnt_inc;
        end else begin
            cur_lsb = base_q + cnt_q;
            nxt_lsb = base_q + cnt_inc;
        end
    end

    // R13: a step advances the beat counter by exactly one
    a_r13_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == CW'($past(cnt_q) + CW'(1))));

    // R14: without step or load the beat position is held
    a_r14_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/fts_write_decode.sv
module fts_write_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] mask,
    output logic             wr_req
);
    always_comb begin
        if (!gw_n) begin
            mask = '1;
        end else if (!bwe_n) begin
            mask = ~bw_n;
        end else begin
            mask = '0;
        end
        wr_req = |mask;
    end
endmodule

// File: rtl/fts_array.sv
module fts_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ce1_n,
    input  logic                              ce2,
    input  logic                              ce3_n,
    input  logic                              adsp_n,
    input  logic                              adsc_n,
    input  logic                              adv_n,
    input  logic                              gw_n,
    input  logic                              bwe_n,
    input  logic [FTS_LANES-1:0]              bw_n,
    input  logic                              oe_n,
    input  logic                              mode,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [FTS_LANES*FTS_LANE_W-1:0]   din,
    output logic [FTS_LANES*FTS_LANE_W-1:0]   dout,
    output logic                              dout_en
);
    localparam int DATA_W = FTS_LANES * FTS_LANE_W;
    localparam int UP_W   = ADDR_W - FTS_CNT_W;

    fts_state_e state_q, state_d;

    logic                 sel, p_take, c_take, take_any;
    logic                 load, cont, step;
    logic [FTS_LANES-1:0] wr_mask, we_mask;
    logic                 wr_req;
    logic [UP_W-1:0]      upper_q;
    logic [FTS_CNT_W-1:0] cur_lsb, nxt_lsb;
    logic [ADDR_W-1:0]    waddr, raddr;
    logic [DATA_W-1:0]    rdata;

    // strobe and select decoding
    always_comb begin
        sel      = !ce1_n && ce2 && !ce3_n;
        p_take   = !adsp_n && !ce1_n;
        c_take   = !adsc_n && !p_take;
        take_any = p_take || c_take;
        load     = take_any && sel;
        cont     = !take_any && (state_q != ST_IDLE);
        step     = cont && !adv_n;
    end

    fts_write_decode #(.LANES(FTS_LANES)) u_dec (
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bw_n   (bw_n),
        .mask   (wr_mask),
        .wr_req (wr_req)
    );

    fts_burst_seq #(.CW(FTS_CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_lsb (addr[FTS_CNT_W-1:0]),
        .load_ilv (mode),
        .step     (step),
        .cur_lsb  (cur_lsb),
        .nxt_lsb  (nxt_lsb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (load) begin
            upper_q <= addr[ADDR_W-1:FTS_CNT_W];
        end
    end

    // write port: controller-start writes at the new address, beats at the beat address
    always_comb begin
        we_mask = '0;
        waddr   = {upper_q, (step ? nxt_lsb : cur_lsb)};
        if (load && c_take && wr_req) begin
            we_mask = wr_mask;
            waddr   = addr;
        end else if (cont && wr_req) begin
            we_mask = wr_mask;
        end
        raddr = {upper_q, cur_lsb};
    end

    fts_array #(.AW(ADDR_W), .LANES(FTS_LANES), .LANE_W(FTS_LANE_W)) u_mem (
        .clk   (clk),
        .we    (we_mask),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = (c_take && wr_req) ? ST_WRITE : ST_READ;
                end
            end
            ST_READ, ST_WRITE: begin
                if (take_any) begin
                    if (!sel) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = (c_take && wr_req) ? ST_WRITE : ST_READ;
                    end
                end else begin
                    state_d = wr_req ? ST_WRITE : ST_READ;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dout    = rdata;
        dout_en = (state_q == ST_READ) && !oe_n;
    end

    // R10: any byte written turns the drive off after that edge
    a_r10_write_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        (|we_mask) |=> !dout_en);

    // R2: a strobe taken while deselected ends the access
    a_r2_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (take_any && !sel) |=> (state_q == ST_IDLE && !dout_en));

    // R4: no array write on the processor-strobe edge
    a_r4_first_beat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        p_take |-> (we_mask == '0));
endmodule

// File: tb/fts_burst_sram_test.sv
module fts_burst_sram_test;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, mode;
    logic [3:0]  bw_n;
    logic [AW-1:0] addr;
    logic [31:0] din;
    logic [31:0] dout;
    logic        dout_en;

    int checks = 0;
    int fails  = 0;

    logic [31:0] shadow [DEPTH];
    logic        m_active, m_wr, m_ilv;
    logic [AW-3:0] m_up;
    logic [1:0]  m_base, m_cnt;

    always #10 clk = ~clk;

    fts_burst_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .mode(mode), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [3:0] f_mask(logic g, logic b, logic [3:0] s);
        if (!g) return 4'hF;
        if (!b) return ~s;
        return 4'h0;
    endfunction

    function automatic logic [31:0] f_merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [AW-1:0] f_cur();
        logic [1:0] l = m_ilv ? (m_base ^ m_cnt) : (m_base + m_cnt);
        return {m_up, l};
    endfunction

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic p, c, s;
        logic [3:0] m;
        p = !adsp_n && !ce1_n;
        c = !adsc_n && !p;
        s = !ce1_n && ce2 && !ce3_n;
        m = f_mask(gw_n, bwe_n, bw_n);
        if (p || c) begin
            if (s) begin
                m_active = 1'b1;
                m_up = addr[AW-1:2]; m_base = addr[1:0]; m_cnt = 2'd0; m_ilv = mode;
                m_wr = c && (m != 0);
                if (m_wr) shadow[addr] = f_merge(shadow[addr], din, m);
            end else begin
                m_active = 1'b0; m_wr = 1'b0;
            end
        end else if (m_active) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            m_wr = (m != 0);
            if (m_wr) shadow[f_cur()] = f_merge(shadow[f_cur()], din, m);
        end
    endtask

    task automatic check_out(string tag);
        logic e = m_active && !m_wr && !oe_n;
        check_val(tag, {31'd0, dout_en}, {31'd0, e});
        if (e) check_val(tag, dout, shadow[f_cur()]);
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic quiet();
        ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; mode = 0; addr = '0; din = '0;
    endtask

    task automatic c_write(logic [AW-1:0] a, logic [31:0] d, string tag);
        quiet(); adsc_n = 0; gw_n = 0; addr = a; din = d;
        tick(tag);
        quiet();
    endtask

    task automatic c_read(logic [AW-1:0] a, logic md, string tag);
        quiet(); adsc_n = 0; addr = a; mode = md;
        tick(tag);
        quiet();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_active = 0; m_wr = 0; m_ilv = 0; m_up = '0; m_base = '0; m_cnt = '0;
        quiet();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check_val("R1 reset", {31'd0, dout_en}, 32'd0);
        rst_n = 1;
        tick("R1 idle");

        for (int i = 0; i < DEPTH; i++) c_write(AW'(i), 32'hA5000000 ^ (i * 32'h00010203), "R6 preload");

        // R6 controller write then read, R12 flow-through data
        c_write(6'd5, 32'hDEADBEEF, "R10 write off");
        c_read(6'd5, 1'b0, "R6 R12 read back");

        // R11 asynchronous output enable
        #2 oe_n = 1; #1 check_val("R11 oe high", {31'd0, dout_en}, 32'd0);
        oe_n = 0; #1 check_val("R11 oe low", {31'd0, dout_en}, 32'd1);

        // R4 processor start ignores write controls; R5 next beat writes a byte; R9 lane
        quiet(); adsp_n = 0; addr = 6'd8; gw_n = 0; din = 32'h11111111;
        tick("R4 first beat read");
        quiet(); bwe_n = 0; bw_n = 4'b1110; din = 32'h000000CC;
        tick("R5 R10 beat write");
        c_read(6'd8, 1'b0, "R9 byte lane 0");
        quiet(); adsc_n = 0; addr = 6'd9; gw_n = 1; bwe_n = 0; bw_n = 4'b0111; din = 32'h77000000;
        tick("R9 lane 3 write");
        c_read(6'd9, 1'b0, "R9 lane 3 read");
        quiet(); adsc_n = 0; addr = 6'd9; bwe_n = 1; bw_n = 4'h0; din = 32'h0;
        tick("R9 bwe high read");

        // R8 global write overrides byte selects
        quiet(); adsc_n = 0; addr = 6'd10; gw_n = 0; bwe_n = 1; bw_n = 4'hF; din = 32'h12345678;
        tick("R8 global");
        c_read(6'd10, 1'b0, "R8 global read");

        // R7 both strobes: processor wins, no write
        quiet(); adsp_n = 0; adsc_n = 0; addr = 6'd11; gw_n = 0; din = 32'hFFFFFFFF;
        tick("R7 both strobes");

        // R3 processor strobe gated by ce1_n: burst continues
        c_read(6'd12, 1'b0, "R3 setup");
        quiet(); ce1_n = 1; adsp_n = 0;
        tick("R3 continue");

        // R2 deselect then ignored write
        quiet(); adsc_n = 0; ce2 = 0; addr = 6'd13;
        tick("R2 deselect");
        quiet(); gw_n = 0; din = 32'h0BAD0BAD;
        tick("R2 ignored write");
        quiet(); ce1_n = 1; adsp_n = 0;
        tick("R3 idle gated");
        c_read(6'd13, 1'b0, "R2 data kept");

        // R13 linear burst from 18
        c_read(6'd18, 1'b0, "R13 start");
        for (int k = 0; k < 4; k++) begin quiet(); adv_n = 0; tick("R13 linear beat"); end

        // R14 interleaved from 17 with a suspend
        c_read(6'd17, 1'b1, "R14 start");
        quiet(); adv_n = 0; tick("R14 beat");
        quiet(); adv_n = 1; tick("R14 hold");
        quiet(); adv_n = 0; tick("R14 beat");
        quiet(); adv_n = 0; tick("R14 beat");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            ce1_n  = ($urandom % 8) == 0;
            ce2    = ($urandom % 8) != 0;
            ce3_n  = ($urandom % 8) == 0;
            adsp_n = ($urandom % 4) != 0;
            adsc_n = ($urandom % 4) != 0;
            adv_n  = $urandom % 2;
            gw_n   = ($urandom % 4) != 0;
            bwe_n  = $urandom % 2;
            bw_n   = 4'($urandom);
            oe_n   = ($urandom % 6) == 0;
            mode   = $urandom % 2;
            addr   = AW'($urandom);
            din    = $urandom;
            tick("R5 R12 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule